// File: doc/BRIEF.md
# Framed SPI Master Transmitter

This block is an SPI master that sends one 8-bit or 16-bit word per frame, most significant bit first, in clock mode 0. A host places a word into a single-entry transmit buffer. The block moves the word into its shift register, runs the serial clock from a programmable divider, and shifts the word out on MOSI. At the same time it shifts in a word from MISO. The received word is delivered with a one-cycle valid pulse.

The select line has two uses. In plain mode it is an active-low chip select that stays low for as long as frames are running. In framed mode it carries a high sync pulse, one bit period wide, for every word. A placement option puts that pulse either on the first data bit or on an extra bit period just ahead of it. If the next word is already buffered when a frame ends, the next frame follows with no idle bit; the only extra bit is the leading sync bit, when that placement is selected.

The configuration inputs are latched at the start of each frame. They are expected to change only while the block is idle.

Top module: `spi_fm_tx`

## Requirements
- R1: Out of reset and whenever no frame is running, `sck_o`, `mosi_o`, `tx_full_o` and `rx_valid_o` are low. `ss_o` is high when `cfg_framed_i` is 0 and low when it is 1.
- R2: `tx_full_o` rises at the clock edge that accepts a write. It falls at the edge where the buffered word moves into the shift register; from idle, that is the next edge. A write while `tx_full_o` is high is dropped and never sent. A write in the cycle the buffer empties is accepted.
- R3: One bit period lasts 2*(`cfg_div_i`+1) clock cycles. Within a frame, `sck_o` is high for `cfg_div_i`+1 cycles and low for `cfg_div_i`+1 cycles.
- R4: `cfg_wide_i`=1 sends `wr_data_i[15:0]` and `cfg_wide_i`=0 sends `wr_data_i[7:0]`, MSB first. `mosi_o` changes only while `sck_o` is low and holds steady while `sck_o` is high.
- R5: `miso_i` is sampled when `sck_o` rises. On the rise of the last bit, `rx_data_o` takes the received word (upper byte zero in 8-bit mode) and `rx_valid_o` is high for exactly that one cycle.
- R6: With `cfg_framed_i`=0, `ss_o` is low during every bit of every frame.
- R7: With `cfg_framed_i`=1, `ss_o` goes high once per frame for exactly one bit period.
- R8: With `cfg_sync_on_data_i`=1, the pulse covers the first data bit: `sck_o` rises `cfg_div_i`+1 cycles after `ss_o` rises, with `ss_o` still high. With it at 0, the pulse fills the bit period before the first data bit, during which `sck_o` stays low, and the first rise comes 3*(`cfg_div_i`+1) cycles after `ss_o` rises.
- R9: When a word is buffered at the end of a frame, the first `sck_o` rise of the next frame comes 2 bit periods after the previous rise if a leading sync bit is inserted, and 1 bit period after it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_div_i | input | DIV_W | Half bit period minus one, in clock cycles |
| cfg_wide_i | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| cfg_framed_i | input | 1 | 1 selects the framed sync pulse on `ss_o` |
| cfg_sync_on_data_i | input | 1 | 1 places the pulse on the first data bit, 0 one bit ahead of it |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | DATA_W | Host write word |
| tx_full_o | output | 1 | Transmit buffer holds a word |
| sck_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_o | output | 1 | Chip select (plain mode) or frame sync (framed mode) |
| rx_data_o | output | DATA_W | Last received word |
| rx_valid_o | output | 1 | One-cycle pulse when `rx_data_o` updates |

## Verification
The assertions check the following on every cycle:
- the SCK high time and the sync pulse width against the divider setting;
- that MOSI holds steady while SCK is high;
- that the receive pulse is single and falls on an SCK rise;
- that the full flag rises only after a write;
- that the select line stays low while SCK toggles in plain mode.

Some behaviour can only be shown by the bench's sweep over every divider value from 0 to 3, both word sizes, both select modes and both pulse placements. This covers the bit order of the sent and received words, where the pulse sits relative to the first SCK rise, and the gap between back-to-back frames. It also covers the dropping of a write made while the buffer is full.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_SHIFT = 2'd2
  } st_e;
endpackage

// File: rtl/spi_fm_clkdiv.sv
module spi_fm_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             phase_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q;
  logic             wrap;

  assign wrap = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  // ticks mark the last cycle of each half bit
  assign rise_o  = run_i & wrap & ~phase_q;
  assign fall_o  = run_i & wrap & phase_q;
endmodule

// File: rtl/spi_fm_shifter.sv
module spi_fm_shifter #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_next_o
);
  localparam int PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] tx_q, rx_q, aligned;

  // narrow words are left-aligned so the MSB is always tx_q[DATA_W-1]
  generate
    if (PAD_W > 0) begin : g_pad
      assign aligned = wide_i ? data_i : {data_i[NARROW_W-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign aligned = data_i;
    end
  endgenerate

  assign rx_next_o = {rx_q[DATA_W-2:0], miso_i};
  assign mosi_o    = tx_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)        tx_q <= aligned;
      else if (shift_i)  tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      if (sample_i)      rx_q <= rx_next_o;
    end
  end
endmodule

// File: rtl/spi_fm_tx.sv
module spi_fm_tx
  import spi_fm_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int DIV_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic              cfg_wide_i,
  input  logic              cfg_framed_i,
  input  logic              cfg_sync_on_data_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              tx_full_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              ss_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_WIDE   = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] LAST_NARROW = BIT_W'(NARROW_W - 1);

  st_e               state_q, state_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              wide_q, framed_q, on_data_q;
  logic              buf_full_q;
  logic [DATA_W-1:0] buf_q;
  logic [DATA_W-1:0] rx_data_q;
  logic              rx_valid_q;

  logic run, phase, rise, fall, last_bit, frame_end, load, accept, pre_needed;
  logic tx_msb;
  logic [DATA_W-1:0] rx_next;

  assign run        = (state_q != ST_IDLE);
  assign last_bit   = (bit_q == (wide_q ? LAST_WIDE : LAST_NARROW));
  assign frame_end  = (state_q == ST_SHIFT) & fall & last_bit;
  assign load       = buf_full_q & ((state_q == ST_IDLE) | frame_end);
  assign accept     = wr_en_i & (~buf_full_q | load);
  assign pre_needed = cfg_framed_i & ~cfg_sync_on_data_i;

  spi_fm_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (cfg_div_i),
    .phase_o(phase),
    .rise_o (rise),
    .fall_o (fall)
  );

  spi_fm_shifter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .wide_i   (cfg_wide_i),
    .data_i   (buf_q),
    .shift_i  ((state_q == ST_SHIFT) & fall & ~last_bit),
    .sample_i ((state_q == ST_SHIFT) & rise),
    .miso_i   (miso_i),
    .mosi_o   (tx_msb),
    .rx_next_o(rx_next)
  );

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    unique case (state_q)
      ST_IDLE: begin
        if (load) begin
          state_d = pre_needed ? ST_PRE : ST_SHIFT;
          bit_d   = '0;
        end
      end
      ST_PRE: begin
        if (fall) state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (fall) begin
          if (!last_bit) begin
            bit_d = bit_q + 1'b1;
          end else if (load) begin
            state_d = pre_needed ? ST_PRE : ST_SHIFT;
            bit_d   = '0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      wide_q     <= 1'b0;
      framed_q   <= 1'b0;
      on_data_q  <= 1'b0;
      buf_full_q <= 1'b0;
      buf_q      <= '0;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      if (load) begin
        wide_q    <= cfg_wide_i;
        framed_q  <= cfg_framed_i;
        on_data_q <= cfg_sync_on_data_i;
      end
      if (accept) begin
        buf_q      <= wr_data_i;
        buf_full_q <= 1'b1;
      end else if (load) begin
        buf_full_q <= 1'b0;
      end
      rx_valid_q <= (state_q == ST_SHIFT) & rise & last_bit;
      if ((state_q == ST_SHIFT) & rise & last_bit)
        rx_data_q <= wide_q ? rx_next : DATA_W'(rx_next[NARROW_W-1:0]);
    end
  end

  always_comb begin
    if (state_q == ST_IDLE)  ss_o = ~cfg_framed_i;
    else if (framed_q)       ss_o = (state_q == ST_PRE) |
                                    ((state_q == ST_SHIFT) & on_data_q & (bit_q == '0));
    else                     ss_o = 1'b0;
  end

  assign sck_o      = (state_q == ST_SHIFT) & phase;
  assign mosi_o     = run & tx_msb;
  assign tx_full_o  = buf_full_q;
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = rx_valid_q;
endmodule

// File: rtl/spi_fm_tx_chk.sv
module spi_fm_tx_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DIV_W-1:0] cfg_div_i,
  input logic             cfg_framed_i,
  input logic             wr_en_i,
  input logic             tx_full_o,
  input logic             sck_o,
  input logic             mosi_o,
  input logic             ss_o,
  input logic             rx_valid_o
);
  localparam int CW = DIV_W + 3;

  logic [CW-1:0] hi_cnt_q, ss_cnt_q, half;

  assign half = CW'(cfg_div_i) + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q <= '0;
      ss_cnt_q <= '0;
    end else begin
      hi_cnt_q <= sck_o ? hi_cnt_q + 1'b1 : '0;
      ss_cnt_q <= !ss_o ? '0 : ((&ss_cnt_q) ? ss_cnt_q : ss_cnt_q + 1'b1);
    end
  end

  a_r2_full_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_full_o) |-> $past(wr_en_i));

  a_r3_sck_high_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sck_o) |-> (hi_cnt_q == half));

  a_r4_mosi_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  a_r5_rx_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $rose(sck_o));

  a_r5_rx_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  a_r6_select_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_framed_i && sck_o) |-> !ss_o);

  a_r7_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ss_o) && cfg_framed_i && $past(cfg_framed_i)) |-> (ss_cnt_q == (half << 1)));
endmodule

bind spi_fm_tx spi_fm_tx_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_div_i   (cfg_div_i),
  .cfg_framed_i(cfg_framed_i),
  .wr_en_i     (wr_en_i),
  .tx_full_o   (tx_full_o),
  .sck_o       (sck_o),
  .mosi_o      (mosi_o),
  .ss_o        (ss_o),
  .rx_valid_o  (rx_valid_o)
);

// File: tb/sim_spi_fm_tx.sv
module sim_spi_fm_tx;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [7:0]  cfg_div = '0;
  logic        cfg_wide = 1'b0, cfg_framed = 1'b0, cfg_od = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tx_full, sck, mosi, miso, ss, rx_valid;
  logic [15:0] rx_data;

  function automatic logic [15:0] slv_fn(input int f);
    return 16'hC3A5 ^ 16'(f * 16'h2B49);
  endfunction

  function automatic int bad(input logic ok, input string req, input logic [31:0] act,
                             input logic [31:0] exp);
    if (!ok) $display("FAIL %s: got %0h expected %0h", req, act, exp);
    return ok ? 0 : 1;
  endfunction

  int tc = 0, tf = 0, mc = 0, mf = 0;
  int frames = 0, bc = 0, cyc = 0, last_rise = 0, ss_rise = 0;
  int b2b_req = 0, b2b_done = 0, wr_idx = 0, w = 8, hh = 1;
  logic psck = 1'b0, pss = 1'b0, pframed = 1'b0;
  logic [15:0] got = '0;
  logic [15:0] mask;
  logic [15:0] exp_tx [64];
  logic [15:0] slv_cur;

  assign slv_cur = slv_fn(frames);
  assign miso    = slv_cur[(cfg_wide ? 15 : 7) - bc];
  assign mask    = cfg_wide ? 16'hFFFF : 16'h00FF;

  spi_fm_tx u0 (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .cfg_div_i         (cfg_div),
    .cfg_wide_i        (cfg_wide),
    .cfg_framed_i      (cfg_framed),
    .cfg_sync_on_data_i(cfg_od),
    .wr_en_i           (wr_en),
    .wr_data_i         (wr_data),
    .tx_full_o         (tx_full),
    .sck_o             (sck),
    .mosi_o            (mosi),
    .miso_i            (miso),
    .ss_o              (ss),
    .rx_data_o         (rx_data),
    .rx_valid_o        (rx_valid)
  );

  // line monitor: bit order, timing, sync placement, received data
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      w  = cfg_wide ? 16 : 8;
      hh = int'(cfg_div) + 1;
      if (rx_valid) begin
        mc++; mf += bad(sck && !psck && bc == w - 1, "R5 rx_valid on last rise", bc, w - 1);
        mc++; mf += bad(rx_data == (slv_cur & mask), "R5 rx_data", rx_data, slv_cur & mask);
      end
      if (sck && !psck) begin
        if (bc != 0) begin
          mc++; mf += bad(cyc - last_rise == 2 * hh, "R3 bit period", cyc - last_rise, 2 * hh);
        end else if (b2b_req != b2b_done) begin
          b2b_done = b2b_req;
          mc++; mf += bad(cyc - last_rise == ((cfg_framed && !cfg_od) ? 4 * hh : 2 * hh),
                          "R9 back-to-back gap", cyc - last_rise,
                          (cfg_framed && !cfg_od) ? 4 * hh : 2 * hh);
        end
        if (cfg_framed) begin
          if (bc == 0) begin
            mc++; mf += bad(cyc - ss_rise == (cfg_od ? hh : 3 * hh), "R8 pulse placement",
                            cyc - ss_rise, cfg_od ? hh : 3 * hh);
          end
          mc++; mf += bad(ss == (bc == 0 && cfg_od), "R7 ss level at rise", ss,
                          (bc == 0 && cfg_od));
        end else begin
          mc++; mf += bad(ss == 1'b0, "R6 select low in frame", ss, 0);
        end
        got = {got[14:0], mosi};
        last_rise = cyc;
        bc++;
        if (bc == w) begin
          mc++; mf += bad((got & mask) == (exp_tx[frames & 63] & mask), "R4 mosi word",
                          got & mask, exp_tx[frames & 63] & mask);
          frames++;
          bc = 0;
        end
      end
      if (!sck && psck) begin
        mc++; mf += bad(cyc - last_rise == hh, "R3 sck high time", cyc - last_rise, hh);
      end
      if (ss && !pss) ss_rise = cyc;
      if (!ss && pss && cfg_framed && pframed) begin
        mc++; mf += bad(cyc - ss_rise == 2 * hh, "R7 pulse width", cyc - ss_rise, 2 * hh);
      end
      psck = sck;
      pss = ss;
      pframed = cfg_framed;
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tc + mc, tf + mf);
    $finish;
  endtask

  task automatic wait_frames(input int target);
    int n = 0;
    while (frames < target) begin
      @(negedge clk);
      n++;
      if (n > WD_LIMIT) begin
        tc++; tf++;
        $display("FAIL watchdog: frames %0d expected %0d", frames, target);
        finish_run();
      end
    end
  endtask

  task automatic run_cfg(input int d, input int wd, input int fr, input int o, input int idx);
    logic [15:0] w0, w1;
    int base;
    @(negedge clk);
    cfg_div = 8'(d); cfg_wide = wd[0]; cfg_framed = fr[0]; cfg_od = o[0];
    repeat (4) @(negedge clk);
    tc++; tf += bad(ss == !fr[0], "R1 idle ss level", ss, !fr[0]);
    tc++; tf += bad(sck == 1'b0 && mosi == 1'b0, "R1 idle sck/mosi", {sck, mosi}, 0);
    base = frames;
    w0 = idx[0] ? (16'h0080 ^ 16'(idx << 9)) : (16'h8001 ^ 16'(idx * 16'h0101));
    w1 = ~w0 ^ 16'(idx);
    exp_tx[wr_idx & 63] = w0; wr_idx++;
    wr_en = 1'b1; wr_data = w0;
    @(negedge clk);
    wr_en = 1'b0;
    tc++; tf += bad(tx_full == 1'b1, "R2 full after write", tx_full, 1);
    @(negedge clk);
    tc++; tf += bad(tx_full == 1'b0, "R2 full clears on load", tx_full, 0);
    repeat (6 * (d + 1)) @(negedge clk);
    exp_tx[wr_idx & 63] = w1; wr_idx++;
    b2b_req++;
    wr_en = 1'b1; wr_data = w1;
    @(negedge clk);
    tc++; tf += bad(tx_full == 1'b1, "R2 full while busy", tx_full, 1);
    wr_data = 16'h5A5A;  // dropped: buffer full
    @(negedge clk);
    wr_en = 1'b0;
    wait_frames(base + 2);
    repeat (40 * (d + 1)) @(negedge clk);
    tc++; tf += bad(frames == base + 2, "R2 write while full dropped", frames - base, 2);
    tc++; tf += bad(sck == 1'b0 && tx_full == 1'b0 && rx_valid == 1'b0,
                    "R1 idle after burst", {sck, tx_full, rx_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tc++; tf += bad(sck == 1'b0 && mosi == 1'b0, "R1 reset sck/mosi", {sck, mosi}, 0);
    tc++; tf += bad(tx_full == 1'b0 && rx_valid == 1'b0, "R1 reset flags", {tx_full, rx_valid}, 0);
    tc++; tf += bad(ss == 1'b1, "R1 reset ss", ss, 1);
    for (int d = 0; d < 4; d++)
      for (int wd = 0; wd < 2; wd++)
        for (int fr = 0; fr < 2; fr++)
          for (int o = 0; o < 2; o++)
            run_cfg(d, wd, fr, o, d * 8 + wd * 4 + fr * 2 + o);
    finish_run();
  end
endmodule